// File: doc/BRIEF.md
# Direct-Mapped Cache with Selectable Write Policy

The block sits between a processor load/store port and a slower next-level memory. It holds 1024 one-word lines, 4 KB in all, over a 32-bit byte address. For every access it reports whether the word was already held. When the word is absent, the requester is held off until the word has been fetched from the next level.

A single compile-time parameter, `WRITE_BACK`, picks the store policy. When it is 0 the block is write-through with write-around. Every store is queued in a small first-in first-out store queue bound for memory, and a store that misses leaves the cache untouched. When it is 1 the block is write-back with write-allocate. Stores change only the cache and mark the line modified. A modified line is copied out to memory when another address displaces it.

The controller has four named states:
- IDLE: accepts requests and serves hits.
- DRAIN: write-through only. It waits for the store queue to empty before a read fill.
- EVICT: write-back only. It writes the displaced modified word to memory.
- FILL: reads the missing word and installs it.

The transitions are:
- IDLE→FILL on a miss that needs a fetch.
- IDLE→DRAIN on a write-through read miss while stores are still queued.
- IDLE→EVICT on a write-back miss whose line is valid and modified.
- DRAIN→FILL once the queue is empty.
- EVICT→FILL on the memory acknowledge.
- FILL→IDLE on the memory acknowledge.

Top module: `dmc_top`

## Requirements
- R1: Address bits [11:2] are the line index and bits [31:12] the tag. An access hits only when its line is valid and the stored tag equals the address tag. Bits [1:0] are ignored, so any byte address within a held word hits and returns that word.
- R2: After reset every line is invalid, `cpu_ready` is 1, `cpu_resp_valid` is 0, `mem_req` is 0, and the first access to any address misses.
- R3: A read hit is reported one cycle after acceptance, with `cpu_resp_hit`=1 and the stored word. It causes no memory read.
- R4: A read miss drops `cpu_ready` and reads the word from memory. It installs the word and reports `cpu_resp_hit`=0 with the fetched word in the cycle after `mem_ack`.
- R5: Starting empty, the byte-address read sequence 0, 4, 8188, 0, 16384, 0 gives miss, miss, miss, hit, miss, miss in both policies, because 16384 and 0 share index 0.
- R6: Once `mem_req` is raised, it stays high with `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle of `mem_ack`. Each acknowledge completes exactly one transfer.
- R7: In write-through mode a store is reported in the cycle after acceptance, without waiting for memory. It updates the line when it hits and reaches memory through the store queue.
- R8: In write-through mode a store miss fetches nothing and leaves its line as it was. The line's old contents still hit, and the stored address still misses on a later read.
- R9: In write-through mode `cpu_ready` is 0 while the store queue is full. Queued stores reach memory in issue order. A read miss is fetched only after the queue has emptied, so it returns the latest stored value.
- R10: In write-back mode a store hit changes only the cache and marks the line modified. It issues no memory write.
- R11: In write-back mode a store miss first fills the line, then writes the store data into it. It is reported with `cpu_resp_hit`=0 in the cycle after `mem_ack`, and the line is left modified.
- R12: In write-back mode a miss on a valid modified line first writes the old word to address {old tag, index, 2'b00}. Only after that write is acknowledged is the read fill request issued.
- R13: In write-back mode a miss on a clean line issues no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, accepted on an edge where `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Block can accept a request this cycle |
| cpu_resp_valid | output | 1 | One-cycle pulse that completes an accepted access |
| cpu_resp_hit | output | 1 | 1 when the completed access hit |
| cpu_rdata | output | 32 | Load result (store data for stores) |
| mem_req | output | 1 | Next-level transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle transfer completion |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
Timing of results:
- A hit, and a write-through store, is due one cycle after the edge that accepts it.
- A fetched access is due one cycle after the edge that samples `mem_ack`.
- A write-back eviction adds a second complete memory handshake ahead of the fill.

The bench drives requests and samples every output on the falling edge. It holds `cpu_req` until `cpu_ready` is seen high and then waits for the `cpu_resp_valid` pulse before comparing. It also counts the falling edges between acceptance and response, so a hit that takes more than one cycle, or a miss that answers in one, is reported.

Memory effects are checked only after their handshake has finished. The bench either waits out the drain delay or inspects the memory model directly after the acknowledged eviction.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_EVICT = 2'd2,
        ST_FILL  = 2'd3
    } dmc_state_e;
endpackage

// File: rtl/dmc_store.sv
module dmc_store #(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_dirty,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dirty
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];
    logic [LINES-1:0]  vld_q;
    logic [LINES-1:0]  drt_q;

    // tag and data arrays carry no reset; the valid vector guards them
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            dat_q[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            drt_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            drt_q[wr_idx] <= wr_dirty;
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = dat_q[rd_idx];
    assign rd_valid = vld_q[rd_idx];
    assign rd_dirty = drt_q[rd_idx];
endmodule

// File: rtl/dmc_wbuf.sv
module dmc_wbuf #(
    parameter int DEPTH = 2,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          empty,
    output logic          full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [AW-1:0]    a_q [DEPTH];
    logic [DW-1:0]    d_q [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) begin
            a_q[wp_q] <= push_addr;
            d_q[wp_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= bump(wp_q);
            if (do_pop)  rp_q <= bump(rp_q);
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    assign head_addr = a_q[rp_q];
    assign head_data = d_q[rp_q];
    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/dmc_top.sv
module dmc_top
    import dmc_pkg::*;
#(
    parameter int WRITE_BACK = 0,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 10,
    parameter int OFS_W      = 2,
    parameter int WBUF_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_resp_valid,
    output logic              cpu_resp_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
    localparam bit WB    = (WRITE_BACK != 0);

    dmc_state_e state_q, state_d;

    logic [IDX_W-1:0]  in_idx, lk_idx, req_idx_q;
    logic [TAG_W-1:0]  in_tag, req_tag_q;
    logic              req_we_q;
    logic [DATA_W-1:0] req_wdata_q;

    logic [TAG_W-1:0]  ln_tag;
    logic [DATA_W-1:0] ln_data;
    logic              ln_vld, ln_drt;
    logic              hit_now, accept;

    logic              st_we, st_dirty;
    logic [IDX_W-1:0]  st_idx;
    logic [TAG_W-1:0]  st_tag;
    logic [DATA_W-1:0] st_data;

    logic              wb_push, wb_pop, wb_empty, wb_full;
    logic [ADDR_W-1:0] wb_head_addr;
    logic [DATA_W-1:0] wb_head_data;

    logic              resp_v_q, resp_h_q;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_ofs;

    assign in_idx     = cpu_addr[OFS_W +: IDX_W];
    assign in_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
    assign unused_ofs = ^cpu_addr[OFS_W-1:0];
    assign lk_idx     = (state_q == ST_IDLE) ? in_idx : req_idx_q;
    assign hit_now    = ln_vld && (ln_tag == in_tag);
    assign cpu_ready  = (state_q == ST_IDLE) && !wb_full;
    assign accept     = cpu_req && cpu_ready;

    dmc_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_tag   (ln_tag),
        .rd_data  (ln_data),
        .rd_valid (ln_vld),
        .rd_dirty (ln_drt),
        .wr_en    (st_we),
        .wr_idx   (st_idx),
        .wr_tag   (st_tag),
        .wr_data  (st_data),
        .wr_dirty (st_dirty)
    );

    generate
        if (WB) begin : g_nobuf
            logic unused_wb;
            assign unused_wb    = wb_push ^ wb_pop;
            assign wb_empty     = 1'b1;
            assign wb_full      = 1'b0;
            assign wb_head_addr = '0;
            assign wb_head_data = '0;
        end else begin : g_buf
            dmc_wbuf #(.DEPTH(WBUF_DEPTH), .AW(ADDR_W), .DW(DATA_W)) u_wbuf (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (wb_push),
                .push_addr ({cpu_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}}),
                .push_data (cpu_wdata),
                .pop       (wb_pop),
                .head_addr (wb_head_addr),
                .head_data (wb_head_data),
                .empty     (wb_empty),
                .full      (wb_full)
            );
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !hit_now && !(cpu_we && !WB)) begin
                    if (WB) state_d = (ln_vld && ln_drt) ? ST_EVICT : ST_FILL;
                    else    state_d = wb_empty ? ST_FILL : ST_DRAIN;
                end
            end
            ST_DRAIN: if (wb_empty) state_d = ST_FILL;
            ST_EVICT: if (mem_ack)  state_d = ST_FILL;
            ST_FILL:  if (mem_ack)  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs: memory port, line writes, store queue
    always_comb begin
        st_we     = 1'b0;
        st_idx    = lk_idx;
        st_tag    = in_tag;
        st_data   = cpu_wdata;
        st_dirty  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        wb_push   = 1'b0;
        wb_pop    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DRAIN: begin
                mem_req   = !wb_empty;
                mem_we    = 1'b1;
                mem_addr  = wb_head_addr;
                mem_wdata = wb_head_data;
                wb_pop    = mem_ack && !wb_empty;
                if (state_q == ST_IDLE && accept && cpu_we) begin
                    if (WB) begin
                        st_we    = hit_now;
                        st_dirty = 1'b1;
                    end else begin
                        wb_push = 1'b1;
                        st_we   = hit_now;
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {ln_tag, req_idx_q, {OFS_W{1'b0}}};
                mem_wdata = ln_data;
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_we   = 1'b0;
                mem_addr = {req_tag_q, req_idx_q, {OFS_W{1'b0}}};
                if (mem_ack) begin
                    st_we    = 1'b1;
                    st_idx   = req_idx_q;
                    st_tag   = req_tag_q;
                    st_data  = req_we_q ? req_wdata_q : mem_rdata;
                    st_dirty = req_we_q;
                end
            end
            default: ;
        endcase
    end

    // request capture and response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_idx_q   <= '0;
            req_tag_q   <= '0;
            req_we_q    <= 1'b0;
            req_wdata_q <= '0;
            resp_v_q    <= 1'b0;
            resp_h_q    <= 1'b0;
            rdata_q     <= '0;
        end else begin
            resp_v_q <= 1'b0;
            resp_h_q <= 1'b0;
            if (state_q == ST_IDLE && accept) begin
                req_idx_q   <= in_idx;
                req_tag_q   <= in_tag;
                req_we_q    <= cpu_we;
                req_wdata_q <= cpu_wdata;
                if (hit_now || (cpu_we && !WB)) begin
                    resp_v_q <= 1'b1;
                    resp_h_q <= hit_now;
                    rdata_q  <= cpu_we ? cpu_wdata : ln_data;
                end
            end
            if (state_q == ST_FILL && mem_ack) begin
                resp_v_q <= 1'b1;
                resp_h_q <= 1'b0;
                rdata_q  <= req_we_q ? req_wdata_q : mem_rdata;
            end
        end
    end

    assign cpu_resp_valid = resp_v_q;
    assign cpu_resp_hit   = resp_h_q;
    assign cpu_rdata      = rdata_q;
endmodule

// File: rtl/dmc_chk.sv
module dmc_chk #(
    parameter int WB     = 0,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              wb_full,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);
    // R6
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

    // R3
    hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> resp_valid);

    // R4
    miss_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |-> $past(mem_ack) || $past(cpu_req && cpu_ready && cpu_we));

    // R9
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_full |-> !cpu_ready);

    generate
        if (WB != 0) begin : g_wb
            // R12
            evict_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
                mem_req && mem_we && mem_ack |=> mem_req && !mem_we);
        end
    endgenerate
endmodule

bind dmc_top dmc_chk #(.WB(WRITE_BACK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_ready  (cpu_ready),
    .resp_valid (cpu_resp_valid),
    .resp_hit   (cpu_resp_hit),
    .wb_full    (wb_full),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/dmc_top_test.sv
module dmc_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int DWB = 0;  // write-back instance
    localparam int DWT = 1;  // write-through instance

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        req [2];
    logic        we [2];
    logic [31:0] addr [2];
    logic [31:0] wdata [2];
    logic        ready [2];
    logic        rv [2];
    logic        rh [2];
    logic [31:0] rdata [2];
    logic        mreq [2];
    logic        mwe [2];
    logic [31:0] maddr [2];
    logic [31:0] mwdata [2];
    logic        mack [2];
    logic [31:0] mrdata [2];

    dmc_top #(.WRITE_BACK(1)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(req[0]), .cpu_we(we[0]), .cpu_addr(addr[0]),
        .cpu_wdata(wdata[0]), .cpu_ready(ready[0]), .cpu_resp_valid(rv[0]), .cpu_resp_hit(rh[0]),
        .cpu_rdata(rdata[0]), .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]),
        .mem_wdata(mwdata[0]), .mem_ack(mack[0]), .mem_rdata(mrdata[0]));

    dmc_top #(.WRITE_BACK(0)) uut_wt (
        .clk(clk), .rst_n(rst_n), .cpu_req(req[1]), .cpu_we(we[1]), .cpu_addr(addr[1]),
        .cpu_wdata(wdata[1]), .cpu_ready(ready[1]), .cpu_resp_valid(rv[1]), .cpu_resp_hit(rh[1]),
        .cpu_rdata(rdata[1]), .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]),
        .mem_wdata(mwdata[1]), .mem_ack(mack[1]), .mem_rdata(mrdata[1]));

    int n_chk = 0;
    int n_fail = 0;
    int wr_cnt [2];
    int rd_cnt [2];
    int mcnt [2];
    int stall_seen = 0;
    logic [31:0] mem_m [longint];
    logic [31:0] gold [longint];
    logic        rvld [2][1024];
    logic [19:0] rtag [2][1024];

    function automatic longint key(input int d, input logic [31:0] a);
        return (longint'(d) << 32) | longint'(a & 32'hFFFF_FFFC);
    endfunction

    function automatic logic [31:0] seed_val(input logic [31:0] a);
        return a ^ {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [31:0] mem_rd(input int d, input logic [31:0] a);
        if (mem_m.exists(key(d, a))) return mem_m[key(d, a)];
        return seed_val(a & 32'hFFFF_FFFC);
    endfunction

    function automatic logic [31:0] gold_rd(input int d, input logic [31:0] a);
        if (gold.exists(key(d, a))) return gold[key(d, a)];
        return seed_val(a & 32'hFFFF_FFFC);
    endfunction

    // next-level memory: acknowledges after three cycles of request
    always @(posedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (!rst_n) begin
                mack[d] <= 1'b0;
                mcnt[d] = 0;
            end else if (mack[d]) begin
                mack[d] <= 1'b0;
            end else if (mreq[d]) begin
                if (mcnt[d] == 2) begin
                    mcnt[d] = 0;
                    mack[d] <= 1'b1;
                    if (mwe[d]) begin
                        mem_m[key(d, maddr[d])] = mwdata[d];
                        wr_cnt[d]++;
                    end else begin
                        mrdata[d] <= mem_rd(d, maddr[d]);
                        rd_cnt[d]++;
                    end
                end else begin
                    mcnt[d]++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic access(input int d, input bit w, input logic [31:0] a, input logic [31:0] wd,
                          output bit h, output logic [31:0] rdv, output int lat);
        req[d] = 1'b1; we[d] = w; addr[d] = a; wdata[d] = wd;
        while (!ready[d]) begin
            stall_seen++;
            @(negedge clk);
        end
        @(negedge clk);
        req[d] = 1'b0;
        lat = 1;
        while (!rv[d]) begin
            @(negedge clk);
            lat++;
        end
        h = rh[d];
        rdv = rdata[d];
    endtask

    // access with expected hit and data taken from the reference view
    task automatic xact(input int d, input bit w, input logic [31:0] a, input logic [31:0] wd, input string rq);
        bit h, exp_h;
        logic [31:0] rdv;
        int lat;
        logic [9:0]  ix = a[11:2];
        logic [19:0] tg = a[31:12];
        exp_h = rvld[d][ix] && (rtag[d][ix] == tg);
        access(d, w, a, wd, h, rdv, lat);
        check(h == exp_h, {rq, " R1 hit flag"}, 32'(h), 32'(exp_h));
        if (!w) check(rdv == gold_rd(d, a), {rq, " load data"}, rdv, gold_rd(d, a));
        if (exp_h || (w && d == DWT)) check(lat == 1, {rq, " R3 R7 one-cycle response"}, lat, 1);
        else                          check(lat > 2, {rq, " R4 miss stall"}, lat, 3);
        if (w) gold[key(d, a)] = wd;
        if (!w || d == DWB) begin
            rvld[d][ix] = 1'b1;
            rtag[d][ix] = tg;
        end
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        bit h;
        logic [31:0] rdv;
        int lat, w0, r0;
        logic [31:0] seqa [6];
        bit          seqh [6];
        seqa = '{32'd0, 32'd4, 32'd8188, 32'd0, 32'd16384, 32'd0};
        seqh = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
        void'($urandom(32'd4242));
        for (int d = 0; d < 2; d++) begin
            req[d] = 0; we[d] = 0; addr[d] = 0; wdata[d] = 0;
            wr_cnt[d] = 0; rd_cnt[d] = 0;
            for (int i = 0; i < 1024; i++) begin rvld[d][i] = 0; rtag[d][i] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        for (int d = 0; d < 2; d++) begin
            check(ready[d] == 1'b1, "R2 ready after reset", 32'(ready[d]), 1);
            check(rv[d] == 1'b0, "R2 no response after reset", 32'(rv[d]), 0);
            check(mreq[d] == 1'b0, "R2 no memory request after reset", 32'(mreq[d]), 0);
        end

        // R5 conflict sequence, fixed expected outcome
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 6; i++) begin
                access(d, 1'b0, seqa[i], 32'd0, h, rdv, lat);
                check(h == seqh[i], "R5 sequence hit/miss", 32'(h), 32'(seqh[i]));
                check(rdv == seed_val(seqa[i]), "R5 R4 sequence data", rdv, seed_val(seqa[i]));
                rvld[d][seqa[i][11:2]] = 1'b1;
                rtag[d][seqa[i][11:2]] = seqa[i][31:12];
            end
        end

        // R1 byte offset ignored
        access(DWB, 1'b0, 32'd2, 32'd0, h, rdv, lat);
        check(h == 1'b1, "R1 byte offset hit", 32'(h), 1);
        check(rdv == seed_val(32'd0), "R1 byte offset data", rdv, seed_val(32'd0));

        // R10 write-back store hit stays in cache
        w0 = wr_cnt[DWB];
        xact(DWB, 1'b1, 32'd4, 32'hCAFE_0004, "R10 store hit");
        repeat (8) @(negedge clk);
        check(wr_cnt[DWB] == w0, "R10 no memory write on store hit", wr_cnt[DWB], w0);
        xact(DWB, 1'b0, 32'd4, 32'd0, "R10 read back");

        // R12 dirty eviction precedes fill
        r0 = rd_cnt[DWB];
        xact(DWB, 1'b0, 32'd4 + 32'd4096, 32'd0, "R12 conflict read");
        check(wr_cnt[DWB] == w0 + 1, "R12 one eviction write", wr_cnt[DWB], w0 + 1);
        check(mem_rd(DWB, 32'd4) == 32'hCAFE_0004, "R12 R6 evicted word in memory",
              mem_rd(DWB, 32'd4), 32'hCAFE_0004);
        check(rd_cnt[DWB] == r0 + 1, "R12 one fill read", rd_cnt[DWB], r0 + 1);

        // R13 clean replacement
        w0 = wr_cnt[DWB];
        xact(DWB, 1'b0, 32'd4 + 32'd8192, 32'd0, "R13 clean replace");
        check(wr_cnt[DWB] == w0, "R13 no write for clean line", wr_cnt[DWB], w0);

        // R11 write-allocate
        r0 = rd_cnt[DWB];
        xact(DWB, 1'b1, 32'h40, 32'hBEEF_0040, "R11 store miss");
        check(rd_cnt[DWB] == r0 + 1, "R11 fill on store miss", rd_cnt[DWB], r0 + 1);
        xact(DWB, 1'b0, 32'h40, 32'd0, "R11 allocated line hits");

        // R7 write-through store hit
        xact(DWT, 1'b1, 32'd4, 32'h7777_0004, "R7 store hit");
        repeat (10) @(negedge clk);
        check(mem_rd(DWT, 32'd4) == 32'h7777_0004, "R7 store reached memory",
              mem_rd(DWT, 32'd4), 32'h7777_0004);
        xact(DWT, 1'b0, 32'd4, 32'd0, "R7 read back");

        // R8 write-around: line 0 keeps address 0
        r0 = rd_cnt[DWT];
        xact(DWT, 1'b1, 32'd4096, 32'h5555_1000, "R8 store miss");
        check(rd_cnt[DWT] == r0, "R8 no fetch on store miss", rd_cnt[DWT], r0);
        xact(DWT, 1'b0, 32'd0, 32'd0, "R8 old line still hits");
        xact(DWT, 1'b0, 32'd4096, 32'd0, "R8 R9 stored address misses");

        // R9 full queue stalls, order kept
        stall_seen = 0;
        xact(DWT, 1'b1, 32'h200, 32'h0000_0A01, "R9 burst");
        xact(DWT, 1'b1, 32'h204, 32'h0000_0A02, "R9 burst");
        xact(DWT, 1'b1, 32'h200, 32'h0000_0A03, "R9 burst");
        xact(DWT, 1'b1, 32'h208, 32'h0000_0A04, "R9 burst");
        check(stall_seen > 0, "R9 ready low while queue full", stall_seen, 1);
        xact(DWT, 1'b0, 32'h200, 32'd0, "R9 read miss after drain");
        check(mem_rd(DWT, 32'h200) == 32'h0000_0A03, "R9 in-order drain",
              mem_rd(DWT, 32'h200), 32'h0000_0A03);

        // random mix, small address space for conflicts
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 400; i++) begin
                logic [31:0] a;
                bit w;
                a = ({28'd0, 4'($urandom % 4)} << 12) | ({29'd0, 3'($urandom % 8)} << 2)
                    | 32'($urandom % 4);
                w = ($urandom % 3) == 0;
                xact(d, w, a, $urandom, "R1 random");
            end
        end
        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule